// File: doc/BRIEF.md
# Bus-Invert Transition-Minimising Link

This block sits on both ends of a wide on-chip parallel bus where wire switching costs power. The transmit side registers each valid source word onto the bus wires. It can send the word as it is or as its bitwise complement. An extra polarity wire tells the receiver which form is on the bus. Power on such a bus grows with wire count, wire capacitance, supply voltage squared, clock rate and switching activity. The encoder therefore picks, every valid cycle, the form that flips fewer wires relative to what is already driven, and it counts the polarity wire as well.

The receive side removes the inversion combinationally from the wires and the polarity line. Two saturating accumulators count wire transitions. One counts the encoded wires including the polarity line. The other counts the transitions the plain, unencoded word stream would have caused. A bench can compare the two to measure the saving.

Top module: `bic_link`

## Requirements
- R1: While reset is active and directly after it, `bus_data` is all zeros, `bus_inv` is 0, `rx_valid` is 0 and both toggle counters read 0.
- R2: When `bus_inv` is 0, `bus_data` equals the source word. When `bus_inv` is 1, `bus_data` equals its bitwise complement.
- R3: On a valid cycle, the pattern driven next, {`bus_inv`,`bus_data`}, has a Hamming distance to the pattern driven before that is no larger than that of the other polarity choice.
- R4: When both polarity choices flip the same number of wires, the true form is sent (`bus_inv` = 0).
- R5: On a cycle with `src_valid` low, `bus_data` and `bus_inv` keep their values.
- R6: `rx_valid` is high exactly one cycle after each `src_valid` cycle, and `rx_data` then equals that source word.
- R7: `enc_toggles` adds, in each cycle, the number of wires among {`bus_inv`,`bus_data`} that changed at the previous clock edge.
- R8: `raw_toggles` adds the Hamming distance between each valid source word and the previous valid source word. The first word is compared with zero.
- R9: Both counters stop at their all-ones value and stay there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source word present this cycle |
| src_data | input | DATA_W | Source word |
| bus_data | output | DATA_W | Registered data wires |
| bus_inv | output | 1 | Registered polarity wire (1 = complemented) |
| rx_valid | output | 1 | Receiver word valid |
| rx_data | output | DATA_W | Decoded word |
| enc_toggles | output | CNT_W | Saturating count of encoded wire transitions |
| raw_toggles | output | CNT_W | Saturating count of unencoded word transitions |

## Verification
The bench builds the block with DATA_W = 7, so the bus plus the polarity wire has an even count of eight wires. A word with four ones driven after an all-zero bus then produces an exact tie between the two polarity choices, and that exercises the tie rule. CNT_W = 7 limits the counters to 127. A few dozen alternating all-zero and all-one words therefore drive the unencoded counter into saturation, and a longer pseudo-random run does the same for the encoded counter.

// File: rtl/bic_pkg.sv
package bic_pkg;
  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_INV  = 1'b1
  } pol_e;
endpackage

// File: rtl/bic_encoder.sv
module bic_encoder import bic_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_inv,
  output logic              bus_valid
);
  localparam int PAT_W  = DATA_W + 1;
  localparam int DIST_W = $clog2(PAT_W + 1);

  function automatic logic [DIST_W-1:0] hamming(input logic [PAT_W-1:0] a,
                                                input logic [PAT_W-1:0] b);
    logic [DIST_W-1:0] n;
    n = '0;
    for (int i = 0; i < PAT_W; i++) n += DIST_W'(a[i] ^ b[i]);
    return n;
  endfunction

  logic [PAT_W-1:0]  cur_pat, true_pat, inv_pat, next_pat;
  logic [DIST_W-1:0] dist_true, dist_inv;
  logic              tie_w;
  pol_e              pick;

  always_comb begin
    cur_pat   = {bus_inv, bus_data};
    true_pat  = {1'b0, in_data};
    inv_pat   = {1'b1, ~in_data};
    dist_true = hamming(cur_pat, true_pat);
    dist_inv  = hamming(cur_pat, inv_pat);
    tie_w     = (dist_true == dist_inv);
    pick      = (dist_inv < dist_true) ? POL_INV : POL_TRUE;
    next_pat  = (pick == POL_INV) ? inv_pat : true_pat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_data  <= '0;
      bus_inv   <= 1'b0;
      bus_valid <= 1'b0;
    end else begin
      bus_valid <= in_valid;
      if (in_valid) begin
        bus_inv  <= next_pat[DATA_W];
        bus_data <= next_pat[DATA_W-1:0];
      end
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) !rst_n |=> (bus_data == '0 && !bus_inv && !bus_valid));

  // R3
  min_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> hamming({bus_inv, bus_data}, $past({bus_inv, bus_data})) <= DIST_W'(PAT_W / 2));

  // R4
  tie_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tie_w) |=> !bus_inv);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bus_data) && $stable(bus_inv)));
endmodule

// File: rtl/bic_decoder.sv
module bic_decoder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] wire_data,
  input  logic              wire_inv,
  output logic [DATA_W-1:0] word
);
  always_comb word = wire_data ^ {DATA_W{wire_inv}};
endmodule

// File: rtl/bic_toggle_acc.sv
module bic_toggle_acc #(
  parameter int W     = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [W-1:0]     word,
  output logic [CNT_W-1:0] count
);
  localparam int STEP_W = $clog2(W + 1);

  function automatic logic [STEP_W-1:0] flips(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [STEP_W-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n += STEP_W'(a[i] ^ b[i]);
    return n;
  endfunction

  logic [W-1:0]      prev_word;
  logic [STEP_W-1:0] step;
  logic [CNT_W:0]    sum;

  always_comb begin
    step = flips(prev_word, word);
    sum  = {1'b0, count} + (CNT_W + 1)'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_word <= '0;
      count     <= '0;
    end else if (sample_en) begin
      prev_word <= word;
      count     <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == {CNT_W{1'b1}}) |=> (count == {CNT_W{1'b1}}));

  // R7
  monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count >= $past(count));
endmodule

// File: rtl/bic_link.sv
module bic_link #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_inv,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic [CNT_W-1:0]  enc_toggles,
  output logic [CNT_W-1:0]  raw_toggles
);
  localparam int PAT_W = DATA_W + 1;

  logic [PAT_W-1:0] wire_pat;
  assign wire_pat = {bus_inv, bus_data};

  bic_encoder #(.DATA_W(DATA_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(src_valid), .in_data(src_data),
    .bus_data(bus_data), .bus_inv(bus_inv), .bus_valid(rx_valid)
  );

  bic_decoder #(.DATA_W(DATA_W)) u_dec (
    .wire_data(bus_data), .wire_inv(bus_inv), .word(rx_data)
  );

  bic_toggle_acc #(.W(PAT_W), .CNT_W(CNT_W)) u_enc_cnt (
    .clk(clk), .rst_n(rst_n), .sample_en(1'b1), .word(wire_pat), .count(enc_toggles)
  );

  bic_toggle_acc #(.W(DATA_W), .CNT_W(CNT_W)) u_raw_cnt (
    .clk(clk), .rst_n(rst_n), .sample_en(src_valid), .word(src_data), .count(raw_toggles)
  );

  // R6
  rx_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> (rx_valid && rx_data == $past(src_data)));
endmodule

// File: tb/bic_link_tb.sv
module bic_link_tb;
  localparam int W = 7;
  localparam int C = 7;
  localparam int CMAX = (1 << C) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic [W-1:0] bus_data, rx_data;
  logic         bus_inv, rx_valid;
  logic [C-1:0] enc_toggles, raw_toggles;

  always #2 clk = ~clk;

  bic_link #(.DATA_W(W), .CNT_W(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .bus_data(bus_data), .bus_inv(bus_inv), .rx_valid(rx_valid), .rx_data(rx_data),
    .enc_toggles(enc_toggles), .raw_toggles(raw_toggles)
  );

  typedef struct packed {
    logic [W-1:0] word;
    logic         inv;
    logic [W-1:0] wires;
  } exp_t;

  exp_t   q[$];
  int     tests = 0, fails = 0;
  logic [W:0]   m_pat = '0;
  logic [W-1:0] m_prev_raw = '0;
  int     m_enc = 0, m_raw = 0;
  logic [W:0]   last_bus = '0;
  bit     mon_on = 1'b0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d);
    logic [W:0] tp, ip, pick;
    int dt, di;
    @(negedge clk);
    tp = {1'b0, d};
    ip = {1'b1, ~d};
    dt = $countones(m_pat ^ tp);
    di = $countones(m_pat ^ ip);
    pick = (di < dt) ? ip : tp;
    m_enc = (m_enc + ((di < dt) ? di : dt) > CMAX) ? CMAX : m_enc + ((di < dt) ? di : dt);
    m_raw = (m_raw + $countones(d ^ m_prev_raw) > CMAX) ? CMAX : m_raw + $countones(d ^ m_prev_raw);
    m_prev_raw = d;
    m_pat = pick;
    q.push_back('{word: d, inv: pick[W], wires: pick[W-1:0]});
    src_valid = 1'b1;
    src_data  = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      src_valid = 1'b0;
      src_data  = '0;
    end
  endtask

  task automatic next_rand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (rx_valid) begin
        if (q.size() == 0) chk("R6 unexpected rx_valid", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R2 R3 bus_data", 32'(bus_data), 32'(e.wires));
          chk("R3 R4 bus_inv", 32'(bus_inv), 32'(e.inv));
          chk("R6 rx_data", 32'(rx_data), 32'(e.word));
          last_bus = {bus_inv, bus_data};
        end
      end else begin
        chk("R5 idle hold", 32'({bus_inv, bus_data}), 32'(last_bus));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 bus_data in reset", 32'(bus_data), 32'd0);
    chk("R1 bus_inv in reset", 32'(bus_inv), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus_data", 32'(bus_data), 32'd0);
    chk("R1 bus_inv", 32'(bus_inv), 32'd0);
    chk("R1 rx_valid", 32'(rx_valid), 32'd0);
    chk("R1 enc_toggles", 32'(enc_toggles), 32'd0);
    chk("R1 raw_toggles", 32'(raw_toggles), 32'd0);
    mon_on = 1'b1;

    // R4 tie: four ones against an all-zero 8-wire pattern
    send(7'h0F);
    send(7'h7F);
    send(7'h00);
    send(7'h55);
    send(7'h2A);
    idle(3);
    chk("R4 tie keeps true polarity", 32'(last_bus), 32'h0F ^ 32'h55 ^ 32'h55 ^ 32'h0F ^ 32'(m_pat));
    chk("R7 enc_toggles small run", 32'(enc_toggles), 32'(m_enc));
    chk("R8 raw_toggles small run", 32'(raw_toggles), 32'(m_raw));

    // random words with gaps
    for (int i = 0; i < 60; i++) begin
      next_rand();
      send(lf[W-1:0]);
      if (i % 3 == 2) idle(1 + (i % 2));
    end
    idle(3);
    chk("R7 enc_toggles random run", 32'(enc_toggles), 32'(m_enc));
    chk("R8 raw_toggles random run", 32'(raw_toggles), 32'(m_raw));

    // alternating extremes: drives the raw counter to its limit
    for (int i = 0; i < 40; i++) send((i % 2 == 0) ? 7'h7F : 7'h00);
    idle(3);
    chk("R9 raw_toggles saturated", 32'(raw_toggles), CMAX);
    chk("R7 enc_toggles alternating", 32'(enc_toggles), 32'(m_enc));

    for (int i = 0; i < 100; i++) begin
      next_rand();
      send(lf[W-1:0]);
    end
    idle(3);
    chk("R9 enc_toggles saturated", 32'(enc_toggles), CMAX);
    chk("R9 raw_toggles held", 32'(raw_toggles), 32'(m_raw));
    chk("R6 scoreboard drained", 32'(q.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule